// File: doc/BRIEF.md
# Write-Path Round-Robin Arbiter

This block merges the write-address and write-data channels of several AXI4 masters onto a single downstream write port. An address handshake is granted to one master. The burst length of that address is latched. From then on, only that master's data beats pass through until the burst completes. Because AXI4 write data carries no ID, this locking keeps data in the same master order as the accepted addresses.

Priority is a one-hot pointer. Each address grant goes to the first requesting master found at or after the pointer, in circular order. The pointer moves only when a complete address-plus-data transaction has finished. It then points to the master just after the one served, and the last master wraps to master 0. Changes in the request pattern alone never move it.

The arbiter sequences through two named states:
- `ST_ADDR` (address arbitration) moves to `ST_DATA` on an address handshake.
- `ST_DATA` (burst forwarding) moves back to `ST_ADDR` when the last data beat is accepted.

Only one burst is in flight at a time. The downstream WLAST is produced from the latched length, not taken from the master.

Top module: `wr_rr_arbiter`

## Requirements
- R1: After reset the block is in `ST_ADDR`. No ready is given to any master, `s_awvalid` and `s_wvalid` are low, and the priority pointer holds the index given by `INIT_PRIO`.
- R2: In `ST_ADDR`, `s_awvalid` is high exactly when any master's awvalid is high. The granted master is the first requester at or after the pointer, in circular index order. Its id, address, length, size and burst fields (master i packed at bits [i*W +: W]) appear on the `s_aw*` outputs. When `s_awready` is high, `m_awready` is high only for that master.
- R3: An address transfer completes in the single cycle in which `s_awvalid` and `s_awready` are both high. The block then enters `ST_DATA` on the next cycle, holding the winner and its awlen.
- R4: In `ST_DATA`, no master receives awready and `s_awvalid` is low.
- R5: In `ST_DATA`, `s_wvalid`, `s_wdata` and `s_wstrb` come from the granted master only. `m_wready` is high only for that master, and only when `s_wready` is high. The wvalid of every other master is ignored.
- R6: `s_wlast` is high on data beat awlen+1 and on no other beat. WLAST is generated from this count, so the master's own last flag has no bearing on it. After that beat is accepted, the block returns to `ST_ADDR`.
- R7: The pointer moves one position past the granted master at the end of each burst, and the last master wraps to master 0. It does not change at any other time.
- R8: In `ST_ADDR`, write data offered by any master is not forwarded: `s_wvalid` is low and `m_wready` is all zero.
- R9: The grant stays constant from the address handshake until the last data beat of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_awid | input | NUM_MST*ID_W | Per-master write id |
| m_awaddr | input | NUM_MST*ADDR_W | Per-master write address |
| m_awlen | input | NUM_MST*8 | Per-master burst length minus one |
| m_awsize | input | NUM_MST*3 | Per-master beat size |
| m_awburst | input | NUM_MST*2 | Per-master burst type |
| m_awvalid | input | NUM_MST | Per-master address valid |
| m_awready | output | NUM_MST | Per-master address ready |
| m_wdata | input | NUM_MST*DATA_W | Per-master write data |
| m_wstrb | input | NUM_MST*DATA_W/8 | Per-master byte strobes |
| m_wvalid | input | NUM_MST | Per-master data valid |
| m_wready | output | NUM_MST | Per-master data ready |
| s_awid | output | ID_W | Downstream write id |
| s_awaddr | output | ADDR_W | Downstream address |
| s_awlen | output | 8 | Downstream burst length |
| s_awsize | output | 3 | Downstream beat size |
| s_awburst | output | 2 | Downstream burst type |
| s_awvalid | output | 1 | Downstream address valid |
| s_awready | input | 1 | Downstream address ready |
| s_wdata | output | DATA_W | Downstream write data |
| s_wstrb | output | DATA_W/8 | Downstream byte strobes |
| s_wlast | output | 1 | Downstream last beat, generated from the count |
| s_wvalid | output | 1 | Downstream data valid |
| s_wready | input | 1 | Downstream data ready |

## Verification
The bench builds the block with four masters, a 4-bit id, 16-bit addresses, 32-bit data and `INIT_PRIO` set to 2. A non-zero start index makes the reset pointer observable. When all four masters request at once, the grants must come out in the order 2, 3, 0, 1, which also exercises the wrap from the last master to the first. Burst lengths of up to six beats, together with random backpressure on both downstream readies, keep the pointer held across long stalls. Masters still waiting for an address keep offering junk write data, which exposes any leakage of data from a master that does not hold the grant.

// File: rtl/wr_arb_pkg.sv
package wr_arb_pkg;
    localparam int LEN_W   = 8;
    localparam int SIZE_W  = 3;
    localparam int BURST_W = 2;

    typedef enum logic [0:0] {
        ST_ADDR = 1'b0,
        ST_DATA = 1'b1
    } arb_state_e;
endpackage

// File: rtl/wr_arb_rrpick.sv
// Circular first-requester pick starting at a one-hot pointer.
module wr_arb_rrpick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] ptr,
    output logic [N-1:0] gnt
);
    logic [N-1:0] upper;
    logic [N-1:0] pool;

    always_comb begin
        // requesters at or above the pointer position
        upper = req & ~(ptr - {{(N-1){1'b0}}, 1'b1});
        pool  = (|upper) ? upper : req;
        // isolate the lowest set bit
        gnt   = pool & (~pool + {{(N-1){1'b0}}, 1'b1});
    end
endmodule

// File: rtl/wr_arb_ohmux.sv
// AND-OR multiplexer driven by a one-hot select.
module wr_arb_ohmux #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic [N-1:0]   sel,
    input  logic [N*W-1:0] din,
    output logic [W-1:0]   dout
);
    always_comb begin
        dout = '0;
        for (int i = 0; i < N; i++) begin
            dout = dout | (din[i*W +: W] & {W{sel[i]}});
        end
    end
endmodule

// File: rtl/wr_rr_arbiter.sv
module wr_rr_arbiter
    import wr_arb_pkg::*;
#(
    parameter int NUM_MST   = 4,
    parameter int ID_W      = 4,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int INIT_PRIO = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_MST*ID_W-1:0]       m_awid,
    input  logic [NUM_MST*ADDR_W-1:0]     m_awaddr,
    input  logic [NUM_MST*8-1:0]          m_awlen,
    input  logic [NUM_MST*3-1:0]          m_awsize,
    input  logic [NUM_MST*2-1:0]          m_awburst,
    input  logic [NUM_MST-1:0]            m_awvalid,
    output logic [NUM_MST-1:0]            m_awready,
    input  logic [NUM_MST*DATA_W-1:0]     m_wdata,
    input  logic [NUM_MST*DATA_W/8-1:0]   m_wstrb,
    input  logic [NUM_MST-1:0]            m_wvalid,
    output logic [NUM_MST-1:0]            m_wready,
    output logic [ID_W-1:0]               s_awid,
    output logic [ADDR_W-1:0]             s_awaddr,
    output logic [7:0]                    s_awlen,
    output logic [2:0]                    s_awsize,
    output logic [1:0]                    s_awburst,
    output logic                          s_awvalid,
    input  logic                          s_awready,
    output logic [DATA_W-1:0]             s_wdata,
    output logic [DATA_W/8-1:0]           s_wstrb,
    output logic                          s_wlast,
    output logic                          s_wvalid,
    input  logic                          s_wready
);
    localparam int STRB_W = DATA_W / 8;
    localparam int AW_BW  = ID_W + ADDR_W + LEN_W + SIZE_W + BURST_W;
    localparam int W_BW   = DATA_W + STRB_W;
    localparam logic [NUM_MST-1:0] INIT_OH =
        {{(NUM_MST-1){1'b0}}, 1'b1} << INIT_PRIO;

    arb_state_e            state_q;
    logic [NUM_MST-1:0]    ptr_q;
    logic [NUM_MST-1:0]    gnt_q;
    logic [LEN_W-1:0]      len_q;
    logic [LEN_W-1:0]      cnt_q;

    logic [NUM_MST-1:0]    pick_gnt;
    logic [NUM_MST-1:0]    aw_sel;
    logic [NUM_MST*AW_BW-1:0] aw_pack;
    logic [NUM_MST*W_BW-1:0]  w_pack;
    logic [AW_BW-1:0]      aw_out;
    logic [W_BW-1:0]       w_out;
    logic                  aw_fire;
    logic                  w_fire;
    logic                  last_beat;

    // per-master channel bundles
    for (genvar g = 0; g < NUM_MST; g++) begin : g_pack
        assign aw_pack[g*AW_BW +: AW_BW] = {
            m_awid[g*ID_W +: ID_W],
            m_awaddr[g*ADDR_W +: ADDR_W],
            m_awlen[g*LEN_W +: LEN_W],
            m_awsize[g*SIZE_W +: SIZE_W],
            m_awburst[g*BURST_W +: BURST_W]
        };
        assign w_pack[g*W_BW +: W_BW] = {
            m_wdata[g*DATA_W +: DATA_W],
            m_wstrb[g*STRB_W +: STRB_W]
        };
    end

    wr_arb_rrpick #(.N(NUM_MST)) u_pick (
        .req (m_awvalid),
        .ptr (ptr_q),
        .gnt (pick_gnt)
    );

    assign aw_sel = (state_q == ST_ADDR) ? pick_gnt : '0;

    wr_arb_ohmux #(.N(NUM_MST), .W(AW_BW)) u_aw_mux (
        .sel  (aw_sel),
        .din  (aw_pack),
        .dout (aw_out)
    );

    wr_arb_ohmux #(.N(NUM_MST), .W(W_BW)) u_w_mux (
        .sel  (gnt_q),
        .din  (w_pack),
        .dout (w_out)
    );

    assign {s_awid, s_awaddr, s_awlen, s_awsize, s_awburst} = aw_out;
    assign {s_wdata, s_wstrb} = w_out;

    assign aw_fire   = s_awvalid && s_awready;
    assign w_fire    = s_wvalid && s_wready;
    assign last_beat = (cnt_q == len_q);

    // state register and captured transaction context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ADDR;
            ptr_q   <= INIT_OH;
            gnt_q   <= '0;
            len_q   <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_ADDR: begin
                    if (aw_fire) begin
                        state_q <= ST_DATA;
                        gnt_q   <= pick_gnt;
                        len_q   <= s_awlen;
                        cnt_q   <= '0;
                    end
                end
                ST_DATA: begin
                    if (w_fire) begin
                        if (last_beat) begin
                            state_q <= ST_ADDR;
                            ptr_q   <= {gnt_q[NUM_MST-2:0], gnt_q[NUM_MST-1]};
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // output decode per state
    always_comb begin
        s_awvalid = 1'b0;
        m_awready = '0;
        s_wvalid  = 1'b0;
        m_wready  = '0;
        s_wlast   = 1'b0;
        unique case (state_q)
            ST_ADDR: begin
                s_awvalid = |m_awvalid;
                m_awready = pick_gnt & {NUM_MST{s_awready}};
            end
            ST_DATA: begin
                s_wvalid  = |(m_wvalid & gnt_q);
                m_wready  = gnt_q & {NUM_MST{s_wready}};
                s_wlast   = last_beat;
            end
        endcase
    end

    AST_AWRDY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_awready)); // R2
    AST_AW_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (s_awvalid && s_awready) |=> (state_q == ST_DATA)); // R3
    AST_NO_AW_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (m_awready == '0 && !s_awvalid)); // R4
    AST_LAST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_wvalid && s_wready && s_wlast) |=> (state_q == ST_ADDR)); // R6
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_wvalid && s_wready && s_wlast) |=> $stable(ptr_q)); // R7
    AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(ptr_q)); // R7
    AST_NO_W_IN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR) |-> (!s_wvalid && m_wready == '0)); // R8
    AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && !(s_wvalid && s_wready && s_wlast)) |=> $stable(gnt_q)); // R9
endmodule

// File: tb/wr_rr_arbiter_bench.sv
module wr_rr_arbiter_bench;
    localparam int N    = 4;
    localparam int IDW  = 4;
    localparam int AW   = 16;
    localparam int DW   = 32;
    localparam int SW   = DW / 8;
    localparam int INIT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [N*IDW-1:0] m_awid;
    logic [N*AW-1:0]  m_awaddr;
    logic [N*8-1:0]   m_awlen;
    logic [N*3-1:0]   m_awsize;
    logic [N*2-1:0]   m_awburst;
    logic [N-1:0]     m_awvalid, m_awready;
    logic [N*DW-1:0]  m_wdata;
    logic [N*SW-1:0]  m_wstrb;
    logic [N-1:0]     m_wvalid, m_wready;
    logic [IDW-1:0]   s_awid;
    logic [AW-1:0]    s_awaddr;
    logic [7:0]       s_awlen;
    logic [2:0]       s_awsize;
    logic [1:0]       s_awburst;
    logic             s_awvalid, s_awready;
    logic [DW-1:0]    s_wdata;
    logic [SW-1:0]    s_wstrb;
    logic             s_wlast, s_wvalid, s_wready;

    // master-side stimulus state
    logic [N-1:0] awv = '0;
    logic [N-1:0] wv  = '0;
    logic [7:0]   alen [N];
    int           tag  [N];
    int           mst  [N];   // 0 idle, 1 address pending, 2 sending data
    int           beat_m [N];

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    function automatic logic [DW-1:0] wd_f(int m, int t, int b);
        return DW'((m << 28) | ((t & 'hfff) << 16) | (b & 'hffff));
    endfunction
    function automatic logic [SW-1:0] st_f(int m, int b);
        return SW'((m + b + 1) & 15);
    endfunction
    function automatic logic [AW-1:0] ad_f(int m, int t);
        return AW'((m << 12) | (t & 'hfff));
    endfunction
    function automatic int pick_f(logic [N-1:0] r, int p);
        for (int k = 0; k < N; k++) begin
            if (r[(p + k) % N]) return (p + k) % N;
        end
        return -1;
    endfunction

    always_comb begin
        for (int i = 0; i < N; i++) begin
            m_awid[i*IDW +: IDW]  = IDW'(tag[i]);
            m_awaddr[i*AW +: AW]  = ad_f(i, tag[i]);
            m_awlen[i*8 +: 8]     = alen[i];
            m_awsize[i*3 +: 3]    = 3'd2;
            m_awburst[i*2 +: 2]   = 2'b01;
            m_wdata[i*DW +: DW]   = (mst[i] == 2) ? wd_f(i, tag[i], beat_m[i]) : (32'hDEAD0000 | DW'(i));
            m_wstrb[i*SW +: SW]   = (mst[i] == 2) ? st_f(i, beat_m[i]) : '0;
        end
        m_awvalid = awv;
        m_wvalid  = wv;
    end

    wr_rr_arbiter #(
        .NUM_MST(N), .ID_W(IDW), .ADDR_W(AW), .DATA_W(DW), .INIT_PRIO(INIT)
    ) u_wr_rr_arbiter (
        .clk(clk), .rst_n(rst_n),
        .m_awid(m_awid), .m_awaddr(m_awaddr), .m_awlen(m_awlen),
        .m_awsize(m_awsize), .m_awburst(m_awburst),
        .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb),
        .m_wvalid(m_wvalid), .m_wready(m_wready),
        .s_awid(s_awid), .s_awaddr(s_awaddr), .s_awlen(s_awlen),
        .s_awsize(s_awsize), .s_awburst(s_awburst),
        .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wlast(s_wlast),
        .s_wvalid(s_wvalid), .s_wready(s_wready)
    );

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // reference model state
    int ptr = INIT, phase = 0, cur = 0, clen = 0;
    bit first_data = 0;
    int acc_aw = -1, acc_w = -1;
    bit w_end = 0;
    int first4 [4];
    int nwin = 0;

    task automatic observe();
        int w;
        logic [N-1:0] exp_rdy;
        acc_aw = -1; acc_w = -1; w_end = 0;
        if (phase == 0) begin
            w = pick_f(awv, ptr);
            chk(s_awvalid == (|awv), "R2 s_awvalid", 64'(s_awvalid), 64'(|awv));
            if (w >= 0) begin
                chk(s_awid == IDW'(tag[w]) && s_awaddr == ad_f(w, tag[w]) &&
                    s_awsize == 3'd2 && s_awburst == 2'b01,
                    "R2 aw fields", 64'(s_awaddr), 64'(ad_f(w, tag[w])));
                chk(s_awlen == alen[w], "R2 awlen", 64'(s_awlen), 64'(alen[w]));
                exp_rdy = s_awready ? (N'(1) << w) : '0;
                chk(m_awready == exp_rdy, "R2 m_awready", 64'(m_awready), 64'(exp_rdy));
                if (s_awready) begin
                    acc_aw = w; phase = 1; cur = w; clen = int'(alen[w]);
                    first_data = 1;
                    if (nwin < 4) first4[nwin] = w;
                    nwin++;
                end
            end else begin
                chk(m_awready == '0, "R2 no grant", 64'(m_awready), 64'(0));
            end
            chk(!s_wvalid && m_wready == '0, "R8 data held off", 64'({s_wvalid, m_wready}), 64'(0));
        end else begin
            chk(m_awready == '0 && !s_awvalid, first_data ? "R3 entered data" : "R4 aw closed",
                64'({s_awvalid, m_awready}), 64'(0));
            first_data = 0;
            exp_rdy = s_wready ? (N'(1) << cur) : '0;
            chk(m_wready == exp_rdy, "R5 R9 m_wready", 64'(m_wready), 64'(exp_rdy));
            chk(s_wvalid == wv[cur], "R5 s_wvalid", 64'(s_wvalid), 64'(wv[cur]));
            if (wv[cur]) begin
                chk(s_wdata == wd_f(cur, tag[cur], beat_m[cur]) && s_wstrb == st_f(cur, beat_m[cur]),
                    "R5 wdata", 64'(s_wdata), 64'(wd_f(cur, tag[cur], beat_m[cur])));
                chk(s_wlast == (beat_m[cur] == clen), "R6 wlast", 64'(s_wlast),
                    64'(beat_m[cur] == clen));
                if (s_wready) begin
                    acc_w = cur;
                    if (beat_m[cur] == clen) begin
                        w_end = 1; phase = 0; ptr = (cur + 1) % N;
                    end
                end
            end
        end
    endtask

    task automatic drive(bit directed);
        if (acc_aw >= 0) begin
            mst[acc_aw] = 2; awv[acc_aw] = 1'b0; beat_m[acc_aw] = 0;
        end
        if (acc_w >= 0) begin
            if (w_end) begin
                mst[acc_w] = 0; tag[acc_w] = tag[acc_w] + 1;
            end else begin
                beat_m[acc_w] = beat_m[acc_w] + 1;
            end
        end
        for (int m = 0; m < N; m++) begin
            if (!directed && mst[m] == 0 && ($urandom % 3) == 0) begin
                mst[m] = 1; awv[m] = 1'b1; alen[m] = 8'($urandom % 6);
            end
            if (mst[m] == 2)      wv[m] = directed ? 1'b1 : (($urandom % 4) != 0);
            else if (mst[m] == 1) wv[m] = ($urandom % 2) != 0;
            else                  wv[m] = 1'b0;
        end
        s_awready = directed ? 1'b1 : (($urandom % 4) != 0);
        s_wready  = directed ? 1'b1 : (($urandom % 4) != 0);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int m = 0; m < N; m++) begin
            alen[m] = '0; tag[m] = m * 16; mst[m] = 0; beat_m[m] = 0;
        end
        s_awready = 1'b0; s_wready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        chk(m_awready == '0 && m_wready == '0 && !s_awvalid && !s_wvalid,
            "R1 reset outputs", 64'({m_awready, m_wready, s_awvalid, s_wvalid}), 64'(0));
        @(posedge clk); #1;
        rst_n = 1'b1;
        // directed: all masters request together with single-beat bursts
        for (int m = 0; m < N; m++) begin
            mst[m] = 1; awv[m] = 1'b1; alen[m] = 8'd0; wv[m] = 1'b1;
        end
        s_awready = 1'b1; s_wready = 1'b1;
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            observe();
            @(posedge clk); #1;
            drive(c < 20);
            if (c == 20) begin
                for (int i = 0; i < 4; i++) begin
                    chk(first4[i] == (INIT + i) % N, "R1 R7 grant order",
                        64'(first4[i]), 64'((INIT + i) % N));
                end
            end
        end
        done = 1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=hung exp=finished");
            report();
        end
    end
endmodule